// File: doc/BRIEF.md
# Synchronous Burst SRAM Address Sequencer

This block is the address front end of a synchronous burst SRAM. On a rising clock edge where either of two active-low address strobes is low, it captures the external word address and the burst-order select. It also clears a small beat counter. On each later edge where the active-low advance input is low, the counter steps by one. While no strobe is seen, the captured address register stays frozen.

The word address sent to the memory core is the captured address with its low bits replaced. In linear order the low bits are the captured low bits plus the beat count. In interleaved order they are the captured low bits XOR the beat count. The upper bits never change during a burst, so a burst wraps inside its aligned group of four words. A new strobe ends the burst at any point and starts a fresh one.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_ni is low, and after its release with no strobe, addr_o is zero.
- R2: When cpu_strobe_ni is low at a rising edge, addr_o equals the addr_i value sampled at that edge, from that edge on.
- R3: ctl_strobe_ni low, or both strobes low, loads the address in the same way as R2.
- R4: At an edge with both strobes high and advance_ni high, addr_o keeps its value.
- R5: With interleave_i captured as 0 (linear order), each advance makes the low two bits (start + n) mod 4, where n is the number of advances since the strobe.
- R6: With interleave_i captured as 1 (interleaved order), the low two bits after n advances are start XOR (n mod 4).
- R7: Without a strobe, addr_o[15:2] never changes, and changes on addr_i have no effect.
- R8: A strobe during a burst restarts the sequence at the new address, even when advance_ni is also low at that edge.
- R9: interleave_i is sampled only at a strobe edge. A change in the middle of a burst does not alter the order.
- R10: After four advances, the low bits return to the captured start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_strobe_ni | input | 1 | Processor-side address strobe, active low |
| ctl_strobe_ni | input | 1 | Controller-side address strobe, active low |
| advance_ni | input | 1 | Burst advance qualifier, active low |
| interleave_i | input | 1 | Burst order select: 1 selects interleaved, 0 selects linear |
| addr_i | input | AW (16) | External word address |
| addr_o | output | AW (16) | Word address presented to the memory core |

## Verification
A corrupted beat counter or captured start value shows on addr_o[1:0] on the edge after the next advance. The bench steps through whole bursts in both orders, so a wrong count appears within one cycle. A captured address or mode that leaks through when no strobe is present shows up as a change in the upper bits, or as a wrong order, at the first edge after the stray input change. For that reason, addr_i and interleave_i are moved in the middle of a burst.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic {ORDER_LINEAR = 1'b0, ORDER_INTERLEAVED = 1'b1} burst_order_e;

  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] cnt,
                                          input burst_order_e ord);
    if (ord == ORDER_INTERLEAVED) return start ^ cnt;
    return start + cnt;
  endfunction
endpackage

// File: rtl/burst_addr_latch.sv
module burst_addr_latch
  import burst_addr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  burst_order_e  order_i,
  output logic [AW-1:0] base_o,
  output burst_order_e  order_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o  <= '0;
      order_o <= ORDER_LINEAR;
    end else if (load_i) begin
      base_o  <= addr_i;
      order_o <= order_i;
    end
  end
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
  parameter int CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          step_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (clear_i) cnt_o <= '0;
    else if (step_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_addr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_strobe_ni,
  input  logic          ctl_strobe_ni,
  input  logic          advance_ni,
  input  logic          interleave_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  localparam int CW = 2;

  logic          load;
  logic          step;
  logic [AW-1:0] base;
  logic [CW-1:0] cnt;
  burst_order_e  order_q;
  burst_order_e  order_in;

  assign load     = !cpu_strobe_ni || !ctl_strobe_ni;
  assign step     = !advance_ni;
  assign order_in = burst_order_e'(interleave_i);

  burst_addr_latch #(.AW(AW)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .addr_i (addr_i),
    .order_i(order_in),
    .base_o (base),
    .order_o(order_q)
  );

  burst_beat_cnt #(.CW(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(load),
    .step_i (step),
    .cnt_o  (cnt)
  );

  assign addr_o = {base[AW-1:CW], beat_low(base[CW-1:0], cnt, order_q)};

  // R2
  load_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (addr_o == $past(addr_i)));
  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load && advance_ni) |=> $stable(addr_o));
  // R7
  upper_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> (addr_o[AW-1:CW] == $past(addr_o[AW-1:CW])));
  // R5
  linear_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load && step && order_q == ORDER_LINEAR)
      |=> (addr_o[CW-1:0] == CW'($past(addr_o[CW-1:0]) + 1'b1)));
  // R6
  interleave_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load && step && order_q == ORDER_INTERLEAVED)
      |=> ((addr_o[CW-1:0] ^ base[CW-1:0]) ==
           CW'(($past(addr_o[CW-1:0]) ^ $past(base[CW-1:0])) + 1'b1)));
endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int AW = 16;

  typedef struct packed {
    logic        cpu_n;
    logic        ctl_n;
    logic        adv_n;
    logic        mode;
    logic [15:0] addr;
    logic [15:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b1, 1'b0, 16'h1232, 16'h1232, 8'd2},  // R2 processor strobe load
    '{1'b1, 1'b1, 1'b0, 1'b1, 16'hFFFF, 16'h1233, 8'd5},  // R5 linear, R7 addr_i ignored
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h1230, 8'd5},  // R5 wrap in group
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'h7777, 16'h1231, 8'd7},  // R7
    '{1'b1, 1'b1, 1'b1, 1'b0, 16'h7777, 16'h1231, 8'd4},  // R4 hold
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'h7777, 16'h1232, 8'd10}, // R10 back to start
    '{1'b1, 1'b0, 1'b0, 1'b1, 16'hABC1, 16'hABC1, 8'd8},  // R8 strobe beats advance, R3
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 16'hABC0, 8'd6},  // R6 interleaved, R9 mode change ignored
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 16'hABC3, 8'd9},  // R9
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 16'hABC2, 8'd6},  // R6
    '{1'b0, 1'b0, 1'b1, 1'b1, 16'h0F03, 16'h0F03, 8'd3},  // R3 both strobes
    '{1'b1, 1'b1, 1'b0, 1'b1, 16'h0000, 16'h0F02, 8'd6},  // R6 start 3
    '{1'b0, 1'b1, 1'b1, 1'b0, 16'h5556, 16'h5556, 8'd8},  // R8 restart mid-burst
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h5557, 8'd5},  // R5
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h5554, 8'd5}   // R5 wrap
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cpu_strobe_ni = 1'b1;
  logic          ctl_strobe_ni = 1'b1;
  logic          advance_ni = 1'b1;
  logic          interleave_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] addr_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  burst_addr_seq #(.AW(AW)) uut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cpu_strobe_ni(cpu_strobe_ni),
    .ctl_strobe_ni(ctl_strobe_ni),
    .advance_ni   (advance_ni),
    .interleave_i (interleave_i),
    .addr_i       (addr_i),
    .addr_o       (addr_o)
  );

  task automatic check(input int req, input logic [AW-1:0] exp);
    n_run++;
    if (addr_o !== exp) begin
      n_fail++;
      $display("FAIL R%0d addr_o=%h expected=%h", req, addr_o, exp);
    end
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1 during reset
    repeat (2) @(negedge clk_i);
    check(1, '0);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check(1, '0);
    @(negedge clk_i);
    for (int i = 0; i < NV; i++) begin
      cpu_strobe_ni = VECS[i].cpu_n;
      ctl_strobe_ni = VECS[i].ctl_n;
      advance_ni    = VECS[i].adv_n;
      interleave_i  = VECS[i].mode;
      addr_i        = VECS[i].addr;
      @(posedge clk_i); #1;
      check(int'(VECS[i].req), VECS[i].exp);
      @(negedge clk_i);
    end
    // R1 reset in mid-burst clears everything
    cpu_strobe_ni = 1'b1; ctl_strobe_ni = 1'b1; advance_ni = 1'b1;
    rst_ni = 1'b0;
    #1 check(1, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check(1, '0);
    @(negedge clk_i);
    // R10 full interleaved cycle from start 2 returns to start
    cpu_strobe_ni = 1'b0; interleave_i = 1'b1; addr_i = 16'h4442;
    @(negedge clk_i);
    cpu_strobe_ni = 1'b1; advance_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    check(10, 16'h4442);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule